// File: doc/BRIEF.md
# Flash Converter Thermometer Encoder and Output Pipeline

This block is the digital back end of a flash analog-to-digital converter. A comparator array delivers a thermometer word with 127 lines. The number of lines that are asserted is the converted value. The block captures that word on the rising edge of the convert clock. On the falling edge it reduces the word to a 7-bit code and applies the selected output coding. On the next rising edge it loads the code into the output register.

Two static active-low controls pick the output coding. One flips the top bit and the other flips the six lower bits. Between them they give four codings: true straight binary, offset two's complement, and the inverted form of each.

The result for a sample captured at rising edge k appears on the output just after rising edge k+1. It stays there until rising edge k+2, so a downstream register clocked at edge k+2 reads it while the next sample is being taken. The output width is a parameter, and a second parameter chooses between an adder tree and a plain counting loop for the count. The controls affect only results encoded after they change.

Top module: `flash_encoder`

## Requirements
- R1: With both controls high (true straight binary), the output equals the number of asserted thermometer lines, from 0 to 127; a word with all lines on gives 1111111.
- R2: A word with no lines on (input below range) gives code 0, and a word with all lines on (input above range) gives code 127, before the coding is applied.
- R3: The thermometer input is sampled only at the rising convert edge; changes to it during the high and low phases that follow do not alter the result of that sample.
- R4: A sample captured at rising edge k appears on `code_o` just after rising edge k+1 and holds through the falling edge until rising edge k+2.
- R5: With `msb_inv_n` low and `lsb_inv_n` high, only bit 6 is inverted (offset two's complement), so count 64 gives 0000000 and count 0 gives 1000000.
- R6: With `lsb_inv_n` low and `msb_inv_n` high, bits 5..0 are inverted and bit 6 is true, so count 0 gives 0111111.
- R7: With both controls low, all seven bits are inverted, so count 0 gives 1111111 and count 127 gives 0000000.
- R8: A control change takes effect for the sample whose falling-edge encode follows the change; results encoded earlier leave the pipeline unchanged.
- R9: While `rst_n` is low at a convert edge, the capture, encode and output registers load the code of zero asserted lines under the current coding (0000000, 1000000, 0111111 or 1111111 for control pairs 11, 01, 10, 00 given as msb,lsb).
- R10: A thermometer word with out-of-place bits is encoded by counting its asserted lines, so one flipped bit moves the code by exactly one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| conv_clk | input | 1 | Convert clock: capture on rise, encode on fall, output on rise |
| rst_n | input | 1 | Active-low synchronous reset, sampled on both convert edges |
| therm_i | input | 127 | Thermometer word from the comparator array, bit i = comparator i |
| msb_inv_n | input | 1 | Active-low control that inverts output bit 6 |
| lsb_inv_n | input | 1 | Active-low control that inverts output bits 5..0 |
| code_o | output | 7 | Registered coded conversion result |

## Verification
The hardest situation to reach from the ports is a thermometer input that changes after it has been captured while the earlier sample is still in flight. That case tells a correct half-cycle pipeline apart from one that encodes the live input at the falling edge. To reach it, the stimulus writes random garbage onto the input right after every rising edge and supplies the real next sample only after the falling edge. Control changes are timed the same way, so that each one lands between two encodes. Random thermometer words, some with single-bit bubbles, are mixed with directed end-of-range words under all four codings.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;

   // Which output fields are flipped, decoded from the two active-low pins.
   typedef struct packed {
      logic top_flip;
      logic low_flip;
   } fe_flip_t;

   function automatic fe_flip_t decode_flips(input logic top_n, input logic low_n);
      fe_flip_t f;
      f.top_flip = ~top_n;
      f.low_flip = ~low_n;
      return f;
   endfunction

endpackage

// File: rtl/fe_capture.sv
module fe_capture #(
   parameter int WIDTH = 127
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("fe_capture: WIDTH must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= d_i;
   end

endmodule

// File: rtl/fe_popcount.sv
module fe_popcount #(
   parameter int IN_W  = 127,
   parameter int CNT_W = 7,
   parameter bit TREE  = 1'b1
) (
   input  logic [IN_W-1:0]  bits_i,
   output logic [CNT_W-1:0] count_o
);

   localparam int LVLS  = (IN_W > 1) ? $clog2(IN_W) : 1;
   localparam int LANES = 1 << LVLS;

   if ((1 << CNT_W) <= IN_W) begin : g_bad_cnt
      $error("fe_popcount: CNT_W too narrow for IN_W");
   end

   if (TREE) begin : g_tree
      for (genvar lv = 0; lv <= LVLS; lv++) begin : g_lv
         localparam int N = LANES >> lv;
         logic [CNT_W-1:0] s [N];
         if (lv == 0) begin : g_leaf
            for (genvar i = 0; i < N; i++) begin : g_i
               if (i < IN_W) begin : g_real
                  assign s[i] = CNT_W'(bits_i[i]);
               end else begin : g_pad
                  assign s[i] = '0;
               end
            end
         end else begin : g_add
            for (genvar i = 0; i < N; i++) begin : g_i
               assign s[i] = g_lv[lv-1].s[2*i] + g_lv[lv-1].s[2*i+1];
            end
         end
      end
      assign count_o = g_lv[LVLS].s[0];
   end else begin : g_loop
      always_comb begin
         count_o = '0;
         for (int i = 0; i < IN_W; i++) begin
            count_o = count_o + CNT_W'(bits_i[i]);
         end
      end
   end

endmodule

// File: rtl/fe_coder.sv
module fe_coder
   import flash_enc_pkg::*;
#(
   parameter int W = 7
) (
   input  logic [W-1:0] bin_i,
   input  logic         top_inv_n,
   input  logic         low_inv_n,
   output logic [W-1:0] code_o
);

   if (W < 2) begin : g_bad_w
      $error("fe_coder: W must be at least 2");
   end

   fe_flip_t flips;
   assign flips = decode_flips(top_inv_n, low_inv_n);

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (b == W - 1) begin : g_top
         assign code_o[b] = bin_i[b] ^ flips.top_flip;
      end else begin : g_low
         assign code_o[b] = bin_i[b] ^ flips.low_flip;
      end
   end

endmodule

// File: rtl/flash_encoder.sv
module flash_encoder #(
   parameter int OUT_W      = 7,
   parameter bit TREE_COUNT = 1'b1
) (
   input  logic                    conv_clk,
   input  logic                    rst_n,
   input  logic [(1<<OUT_W)-2:0]   therm_i,
   input  logic                    msb_inv_n,
   input  logic                    lsb_inv_n,
   output logic [OUT_W-1:0]        code_o
);

   localparam int LINES = (1 << OUT_W) - 1;
   localparam logic [OUT_W-1:0] TOP_MASK = OUT_W'(1) << (OUT_W - 1);
   localparam logic [OUT_W-1:0] LOW_MASK = TOP_MASK - OUT_W'(1);

   if (OUT_W < 2 || OUT_W > 10) begin : g_bad_out_w
      $error("flash_encoder: OUT_W must lie in 2..10");
   end

   logic [LINES-1:0] cap_q;
   logic [OUT_W-1:0] count;
   logic [OUT_W-1:0] coded;
   logic [OUT_W-1:0] zero_coded;
   logic [OUT_W-1:0] enc_q;

   // Stage 1: comparator word captured on the rising edge.
   fe_capture #(.WIDTH(LINES)) u_capture (
      .clk   (conv_clk),
      .rst_n (rst_n),
      .d_i   (therm_i),
      .q_o   (cap_q)
   );

   fe_popcount #(.IN_W(LINES), .CNT_W(OUT_W), .TREE(TREE_COUNT)) u_count (
      .bits_i  (cap_q),
      .count_o (count)
   );

   fe_coder #(.W(OUT_W)) u_coder (
      .bin_i     (count),
      .top_inv_n (msb_inv_n),
      .low_inv_n (lsb_inv_n),
      .code_o    (coded)
   );

   fe_coder #(.W(OUT_W)) u_zero_coder (
      .bin_i     ('0),
      .top_inv_n (msb_inv_n),
      .low_inv_n (lsb_inv_n),
      .code_o    (zero_coded)
   );

   // Stage 2: encode on the falling edge.
   always_ff @(negedge conv_clk) begin
      if (!rst_n) enc_q <= zero_coded;
      else        enc_q <= coded;
   end

   // Stage 3: output register on the next rising edge.
   always_ff @(posedge conv_clk) begin
      if (!rst_n) code_o <= zero_coded;
      else        code_o <= enc_q;
   end

   // R1
   bin_true_chk: assert property (@(posedge conv_clk) disable iff (!rst_n)
      ($past(rst_n, 1) && $past(rst_n, 2) &&
       $past(msb_inv_n, 1) && $past(msb_inv_n, 2) &&
       $past(lsb_inv_n, 1) && $past(lsb_inv_n, 2))
      |-> code_o == OUT_W'($countones($past(therm_i, 2))));

   // R2
   full_scale_chk: assert property (@(posedge conv_clk) disable iff (!rst_n)
      ($past(rst_n, 1) && $past(rst_n, 2) && ($past(therm_i, 2) == '1) &&
       $past(msb_inv_n, 1) && $past(msb_inv_n, 2) &&
       $past(lsb_inv_n, 1) && $past(lsb_inv_n, 2))
      |-> code_o == '1);

   // R5
   top_flip_chk: assert property (@(posedge conv_clk) disable iff (!rst_n)
      ($past(rst_n, 1) && $past(rst_n, 2) &&
       !$past(msb_inv_n, 1) && !$past(msb_inv_n, 2) &&
       $past(lsb_inv_n, 1) && $past(lsb_inv_n, 2))
      |-> code_o == (OUT_W'($countones($past(therm_i, 2))) ^ TOP_MASK));

   // R6
   low_flip_chk: assert property (@(posedge conv_clk) disable iff (!rst_n)
      ($past(rst_n, 1) && $past(rst_n, 2) &&
       $past(msb_inv_n, 1) && $past(msb_inv_n, 2) &&
       !$past(lsb_inv_n, 1) && !$past(lsb_inv_n, 2))
      |-> code_o == (OUT_W'($countones($past(therm_i, 2))) ^ LOW_MASK));

   // R7
   all_flip_chk: assert property (@(posedge conv_clk) disable iff (!rst_n)
      ($past(rst_n, 1) && $past(rst_n, 2) &&
       !$past(msb_inv_n, 1) && !$past(msb_inv_n, 2) &&
       !$past(lsb_inv_n, 1) && !$past(lsb_inv_n, 2))
      |-> code_o == ~OUT_W'($countones($past(therm_i, 2))));

   // R9
   rst_zero_chk: assert property (@(posedge conv_clk) disable iff (!rst_n)
      !$past(rst_n)
      |-> code_o == {~$past(msb_inv_n), {(OUT_W-1){~$past(lsb_inv_n)}}});

endmodule

// File: tb/flash_encoder_bench.sv
`timescale 1ns/1ps
module flash_encoder_bench;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [126:0] therm;
   logic         msb_n;
   logic         lsb_n;
   logic [6:0]   code_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [6:0] held;
   logic [6:0] pend;
   string      held_tag;
   string      pend_tag;
   bit         prev_m;
   bit         prev_l;

   always #2.5 clk = ~clk;

   flash_encoder u_flash_encoder (
      .conv_clk  (clk),
      .rst_n     (rst_n),
      .therm_i   (therm),
      .msb_inv_n (msb_n),
      .lsb_inv_n (lsb_n),
      .code_o    (code_o)
   );

   function automatic logic [6:0] ones_of(input logic [126:0] w);
      logic [6:0] n = '0;
      for (int i = 0; i < 127; i++) n = n + 7'(w[i]);
      return n;
   endfunction

   function automatic logic [6:0] code_of(input logic [6:0] n, input bit mn, input bit ln);
      logic [6:0] v = n;
      if (!mn) v[6]   = ~v[6];
      if (!ln) v[5:0] = ~v[5:0];
      return v;
   endfunction

   function automatic logic [126:0] thermo(input int n);
      logic [126:0] w = '0;
      for (int i = 0; i < 127; i++) w[i] = (i < n);
      return w;
   endfunction

   function automatic logic [126:0] garbage();
      logic [127:0] g = {$urandom, $urandom, $urandom, $urandom};
      return g[126:0];
   endfunction

   task automatic chk(input string tag, input logic [6:0] got, input logic [6:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   // One pipeline step: drive a sample in the low phase, check at the rise.
   task automatic step(input logic [126:0] w, input bit mn, input bit ln, input string tag);
      @(negedge clk);
      #1;
      chk("R4", code_o, held);          // R4: output holds across the falling edge
      therm = w;
      msb_n = mn;
      lsb_n = ln;
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      held     = pend;
      held_tag = pend_tag;
      pend     = code_of(ones_of(w), mn, ln);
      pend_tag = tag;
      chk(held_tag, code_o, held);
      therm = garbage();                // R3: input scrambled after capture
      prev_m = mn;
      prev_l = ln;
   endtask

   function automatic string tag_for(input logic [126:0] w, input bit bubble, input bit mn,
                                     input bit ln, input bit changed);
      int n = int'(ones_of(w));
      if (bubble)                 return "R10";
      if (changed)                return "R8";
      if (n == 0 || n == 127)     return "R2";
      if (mn && ln)               return "R1";
      if (!mn && ln)              return "R5";
      if (mn && !ln)              return "R6";
      return "R7";
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7321));
      rst_n = 1'b0;
      msb_n = 1'b1;
      lsb_n = 1'b1;
      therm = '1;

      // R9: reset value under each of the four codings (msb,lsb)
      for (int c = 3; c >= 0; c--) begin
         @(negedge clk);
         #1;
         msb_n = c[1];
         lsb_n = c[0];
         therm = garbage();
         @(posedge clk);
         @(posedge clk);
         #1;
         chk("R9", code_o, code_of(7'd0, c[1], c[0]));
      end

      // Back to true binary before release; pipeline holds coded zero.
      @(negedge clk);
      #1;
      msb_n = 1'b1;
      lsb_n = 1'b1;
      @(posedge clk);
      @(posedge clk);
      #1;
      chk("R9", code_o, 7'd0);
      held = 7'd0;
      pend = 7'd0;
      held_tag = "R9";
      pend_tag = "R9";
      prev_m = 1'b1;
      prev_l = 1'b1;

      // Directed range ends and codings
      step('0, 1, 1, "R2");
      step('1, 1, 1, "R2");
      step(thermo(127), 1, 1, "R1");
      step(thermo(1), 1, 1, "R1");
      step(thermo(64), 0, 1, "R8");
      step(thermo(64), 0, 1, "R5");
      step(thermo(0), 0, 1, "R5");
      step(thermo(0), 1, 0, "R8");
      step(thermo(0), 1, 0, "R6");
      step(thermo(127), 1, 0, "R6");
      step(thermo(0), 0, 0, "R8");
      step(thermo(0), 0, 0, "R7");
      step(thermo(127), 0, 0, "R7");
      step(thermo(37), 1, 1, "R8");
      step(thermo(90), 1, 1, "R3");
      step(thermo(5), 1, 1, "R3");
      // R10: bubbles above and below the transition point
      step(thermo(40) | (127'd1 << 80), 1, 1, "R10");
      step(thermo(40) & ~(127'd1 << 10), 1, 1, "R10");
      step(thermo(126) | (127'd1 << 126), 1, 1, "R10");

      // Constrained random mix
      for (int k = 0; k < 400; k++) begin
         int n        = $urandom_range(0, 127);
         bit bubble   = ($urandom_range(0, 5) == 0);
         bit mn       = prev_m;
         bit ln       = prev_l;
         logic [126:0] w = thermo(n);
         if ($urandom_range(0, 7) == 0) begin
            mn = 1'($urandom);
            ln = 1'($urandom);
         end
         if (bubble) w[$urandom_range(0, 126)] ^= 1'b1;
         step(w, mn, ln, tag_for(w, bubble, mn, ln, (mn != prev_m) || (ln != prev_l)));
      end

      // Flush the pipeline
      step('0, 1, 1, "R2");
      step('0, 1, 1, "R2");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule